// File: doc/BRIEF.md
# Multi-Channel Memory-to-Memory DMA Engine

This block copies blocks of data from one memory region to another on behalf of software. Each channel is set up through a word-wide register bus that sits at a configurable base offset. Software loads a source address, a destination address and an element count, then writes the channel's control word with the enable bit set. The engine then moves the data one element at a time over a request/response memory master port. Each element is 1, 2, 4 or 8 bytes. Either end of the copy can step through memory or stay at one address, so a FIFO-style peripheral port can be drained or filled.

Only one channel moves data at any time. When several channels are waiting, the lowest-numbered one is served first. When a transfer completes, the channel drops its enable bit and raises its own terminal-count flag in a shared status word. Software clears that flag by writing a one to it.

Top module: `dma4_engine`

## Requirements
- R1: Register address = base offset + 8 × channel + slot. The slots are: 0 control, 1 count, 2 source high word, 3 source low word, 4 destination high word, 5 destination low word, 6 chain-pointer high word, 7 chain-pointer low word. Every slot reads back the last value written to it.
- R2: A write to one 32-bit half of a 64-bit address register replaces that half only. The other half keeps its value.
- R3: A control write with bit 31 set arms the channel only when bits 15:0 of its count register are nonzero. Count bits 31:16 are ignored. A zero count produces no memory traffic and no status change.
- R4: The element width is 1 << control[26:25] bytes, and this code is placed on the request size field. Elements travel in the low bytes of the 64-bit data bus in little-endian order. Unused write-data bytes are zero.
- R5: Control bit 24 makes the destination address advance by the width after each element. Control bit 23 does the same for the source. When a bit is clear, that address stays fixed.
- R6: Each element is one read request, then its read response, then one write request. A request that is not accepted keeps its address, direction, size and data unchanged until it is accepted.
- R7: After its last write is accepted, a channel clears control bit 31 and sets status bit (31 − channel).
- R8: The status word sits at base offset + 0x20. Writing it clears every bit that is one in the written value. A completion that sets a bit in the same cycle takes precedence.
- R9: Only one channel transfers at a time. Among the armed channels, the lowest-numbered one starts first.
- R10: `busy` is high from the start of a transfer until its completion is visible in the status word, and it is high whenever a memory request is valid.
- R11: Register offsets that are not implemented read as zero, and writes to them change nothing.
- R12: After reset, every channel register and the status word read zero, `busy` is low, and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address (absolute) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 64 | Byte address of the element |
| mem_req_size | output | 2 | log2 of element bytes |
| mem_req_wdata | output | 64 | Write data, element in the low bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data, element in the low bytes |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench builds the block with four channels and a base offset of 0x100. With four channels, three of them can queue behind a running transfer, which exercises the priority order and the placement of three status bits at once. With this base, the status word lands at 0x120, and the probes just below the base and just above the status word land on unimplemented offsets. The memory model accepts requests on an irregular ready pattern, which exercises request holding. The bench also places a destination above the 4 GiB line, which shows that both address halves reach the port.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
   localparam int CTL_EN   = 31;
   localparam int CTL_WHI  = 26;
   localparam int CTL_WLO  = 25;
   localparam int CTL_DINC = 24;
   localparam int CTL_SINC = 23;
   localparam int SLOTS    = 8;
   localparam int STAT_REL = 32;

   typedef struct packed {
      logic [63:0] src;
      logic [63:0] dst;
      logic [1:0]  wcode;
      logic        sinc;
      logic        dinc;
      logic [15:0] cnt;
   } xfer_cfg_t;

   typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} mv_state_t;
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
   import dma4_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int REG_AW   = 10,
   parameter int BASE_OFF = 256,
   localparam int IW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_we,
   input  logic [REG_AW-1:0]            reg_addr,
   input  logic [31:0]                  reg_wdata,
   output logic [31:0]                  reg_rdata,
   input  logic                         take,
   input  logic [IW-1:0]                take_idx,
   input  logic                         done_vld,
   input  logic [IW-1:0]                done_idx,
   output logic [NUM_CH-1:0]            armed,
   output xfer_cfg_t [NUM_CH-1:0]       cfg
);
   logic [REG_AW-1:0]             rel;
   logic                          chan_hit, stat_hit;
   logic [REG_AW-4:0]             sel_ch;
   logic [2:0]                    slot;
   logic [NUM_CH-1:0][31:0]       rd_word;
   logic [31:0]                   stat_q, set_mask;

   assign rel      = reg_addr - REG_AW'(BASE_OFF);
   assign chan_hit = rel < REG_AW'(NUM_CH * SLOTS);
   assign stat_hit = rel == REG_AW'(STAT_REL);
   assign sel_ch   = rel[REG_AW-1:3];
   assign slot     = rel[2:0];
   assign set_mask = done_vld ? (32'h8000_0000 >> done_idx) : 32'h0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic        hit;
      logic [31:0] ctrl, cnt, word;
      logic [63:0] src, dst, chain;
      logic        armed_q;

      assign hit = reg_we && chan_hit && (sel_ch == (REG_AW-3)'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ctrl <= '0; cnt <= '0; src <= '0; dst <= '0; chain <= '0;
            armed_q <= 1'b0;
         end else begin
            if (done_vld && done_idx == IW'(i)) ctrl[CTL_EN] <= 1'b0;
            if (take && take_idx == IW'(i)) armed_q <= 1'b0;
            if (hit) begin
               case (slot)
                  3'd0: begin
                     ctrl <= reg_wdata;
                     if (reg_wdata[CTL_EN] && cnt[15:0] != 16'd0) armed_q <= 1'b1;
                  end
                  3'd1: cnt          <= reg_wdata;
                  3'd2: src[63:32]   <= reg_wdata;
                  3'd3: src[31:0]    <= reg_wdata;
                  3'd4: dst[63:32]   <= reg_wdata;
                  3'd5: dst[31:0]    <= reg_wdata;
                  3'd6: chain[63:32] <= reg_wdata;
                  default: chain[31:0] <= reg_wdata;
               endcase
            end
         end
      end

      always_comb begin
         case (slot)
            3'd0: word = ctrl;
            3'd1: word = cnt;
            3'd2: word = src[63:32];
            3'd3: word = src[31:0];
            3'd4: word = dst[63:32];
            3'd5: word = dst[31:0];
            3'd6: word = chain[63:32];
            default: word = chain[31:0];
         endcase
      end

      assign rd_word[i] = word;
      assign armed[i]   = armed_q;
      assign cfg[i]     = '{src: src, dst: dst, wcode: ctrl[CTL_WHI:CTL_WLO],
                            sinc: ctrl[CTL_SINC], dinc: ctrl[CTL_DINC], cnt: cnt[15:0]};

      // R3: a channel never becomes armed while its element count is zero
      a_r3_arm_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(armed_q) |-> cnt[15:0] != 16'd0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else stat_q <= (stat_q & ~((reg_we && stat_hit) ? reg_wdata : 32'h0)) | set_mask;
   end

   always_comb begin
      reg_rdata = '0;
      if (chan_hit)      reg_rdata = rd_word[sel_ch[IW-1:0]];
      else if (stat_hit) reg_rdata = stat_q;
   end

   // R8: a completion flag is present after its completion cycle even under a clearing write
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld |=> (stat_q & $past(set_mask)) == $past(set_mask));
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
   parameter int NUM_CH = 4,
   localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] armed,
   output logic              grant_vld,
   output logic [IW-1:0]     grant_idx
);
   logic [NUM_CH:0]   seen;
   logic [NUM_CH-1:0] gnt;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NUM_CH; i++) begin : g_pri
      assign gnt[i]    = armed[i] & ~seen[i];
      assign seen[i+1] = seen[i] | armed[i];
   end

   assign grant_vld = seen[NUM_CH];

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (gnt[i]) grant_idx = IW'(i);
   end

   // R9: at most one channel granted at any time
   a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
   import dma4_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int IW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] start_idx,
   input  xfer_cfg_t     start_cfg,
   output logic          idle,
   output logic          busy,
   output logic          done_vld,
   output logic [IW-1:0] done_idx,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic          mem_req_write,
   output logic [63:0]   mem_req_addr,
   output logic [1:0]    mem_req_size,
   output logic [63:0]   mem_req_wdata,
   input  logic          mem_rsp_valid,
   input  logic [63:0]   mem_rsp_rdata
);
   mv_state_t   st;
   logic [63:0] s_addr, d_addr, data_q, step;
   logic [15:0] remain;
   logic [1:0]  wcode_q;
   logic        sinc_q, dinc_q;
   logic [IW-1:0] idx_q;

   function automatic logic [63:0] lane_mask(input logic [1:0] w);
      case (w)
         2'd0:    return 64'h0000_0000_0000_00FF;
         2'd1:    return 64'h0000_0000_0000_FFFF;
         2'd2:    return 64'h0000_0000_FFFF_FFFF;
         default: return {64{1'b1}};
      endcase
   endfunction

   assign step          = 64'(1) << wcode_q;
   assign idle          = (st == S_IDLE);
   assign busy          = !idle || done_vld;
   assign mem_req_valid = (st == S_RD) || (st == S_WR);
   assign mem_req_write = (st == S_WR);
   assign mem_req_addr  = (st == S_WR) ? d_addr : s_addr;
   assign mem_req_size  = wcode_q;
   assign mem_req_wdata = data_q;
   assign done_idx      = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_IDLE; s_addr <= '0; d_addr <= '0; data_q <= '0; remain <= '0;
         wcode_q <= '0; sinc_q <= 1'b0; dinc_q <= 1'b0; idx_q <= '0; done_vld <= 1'b0;
      end else begin
         done_vld <= 1'b0;
         case (st)
            S_IDLE: if (start) begin
               s_addr  <= start_cfg.src;
               d_addr  <= start_cfg.dst;
               wcode_q <= start_cfg.wcode;
               sinc_q  <= start_cfg.sinc;
               dinc_q  <= start_cfg.dinc;
               remain  <= start_cfg.cnt;
               idx_q   <= start_idx;
               st      <= S_RD;
            end
            S_RD:   if (mem_req_ready) st <= S_WAIT;
            S_WAIT: if (mem_rsp_valid) begin
               data_q <= mem_rsp_rdata & lane_mask(wcode_q);
               st     <= S_WR;
            end
            default: if (mem_req_ready) begin
               if (sinc_q) s_addr <= s_addr + step;
               if (dinc_q) d_addr <= d_addr + step;
               remain <= remain - 16'd1;
               if (remain == 16'd1) begin
                  st       <= S_IDLE;
                  done_vld <= 1'b1;
               end else begin
                  st <= S_RD;
               end
            end
         endcase
      end
   end

   // R6: a stalled request holds every request field
   a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_write) && $stable(mem_req_size) && $stable(mem_req_wdata));

   // R10: a valid request implies busy
   a_r10_busy_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy);
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
   import dma4_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int REG_AW   = 10,
   parameter int BASE_OFF = 256,
   parameter int MEM_DW   = 64,
   localparam int IW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [63:0]       mem_req_addr,
   output logic [1:0]        mem_req_size,
   output logic [63:0]       mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [63:0]       mem_rsp_rdata,
   output logic              busy
);
   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must be 1..4 so channel slots stay below the status word");
   end
   if (MEM_DW != 64) begin : g_bad_dw
      $error("MEM_DW must be 64 to carry the widest element");
   end
   if (BASE_OFF + STAT_REL >= (1 << REG_AW)) begin : g_bad_base
      $error("BASE_OFF leaves no room for the status word in REG_AW bits");
   end

   logic [NUM_CH-1:0]       armed;
   xfer_cfg_t [NUM_CH-1:0]  cfg;
   logic                    grant_vld, mv_idle, start, done_vld;
   logic [IW-1:0]           grant_idx, done_idx;

   assign start = grant_vld && mv_idle;

   dma4_regs #(.NUM_CH(NUM_CH), .REG_AW(REG_AW), .BASE_OFF(BASE_OFF)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take(start), .take_idx(grant_idx),
      .done_vld(done_vld), .done_idx(done_idx), .armed(armed), .cfg(cfg));

   dma4_arb #(.NUM_CH(NUM_CH)) u_arb (
      .clk(clk), .rst_n(rst_n), .armed(armed), .grant_vld(grant_vld), .grant_idx(grant_idx));

   dma4_mover #(.NUM_CH(NUM_CH)) u_mover (
      .clk(clk), .rst_n(rst_n), .start(start), .start_idx(grant_idx),
      .start_cfg(cfg[grant_idx]), .idle(mv_idle), .busy(busy),
      .done_vld(done_vld), .done_idx(done_idx),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata));
endmodule

// File: tb/tb_dma4_engine.sv
`timescale 1ns/1ps
module tb_dma4_engine;
   localparam int B = 256;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
   logic [63:0] mem_req_addr, mem_req_wdata;
   logic [1:0]  mem_req_size;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_rdata = '0;
   logic        busy;

   int checks = 0, fails = 0, writes_seen = 0, rdy_cnt = 0;
   logic [7:0] mem [4096];

   typedef struct packed { logic [63:0] a; logic [1:0] sz; logic [63:0] d; } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;

   dma4_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata), .busy(busy));

   function automatic logic [63:0] memword(input logic [63:0] a);
      logic [63:0] v;
      for (int b = 0; b < 8; b++) v[8*b +: 8] = mem[(a[11:0] + 12'(b)) & 12'hFFF];
      return v;
   endfunction

   // memory model: one-cycle read latency, irregular ready
   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 7 + 3);
      end else if (mem_req_valid && mem_req_ready) begin
         if (!mem_req_write) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_rdata <= memword(mem_req_addr);
         end else begin
            for (int b = 0; b < 8; b++)
               if (b < (1 << mem_req_size))
                  mem[(mem_req_addr[11:0] + 12'(b)) & 12'hFFF] <= mem_req_wdata[8*b +: 8];
         end
      end
      rdy_cnt       <= rdy_cnt + 1;
      mem_req_ready <= (rdy_cnt % 3) != 1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every accepted write is compared with the next expected item
   always @(negedge clk) begin
      if (rst_n && mem_req_valid && mem_req_ready && mem_req_write) begin
         writes_seen++;
         if (q.size() == 0) begin
            chk("R6 unexpected write", mem_req_addr, 64'hX);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk("R5 write address", mem_req_addr, e.a);
            chk("R4 write size", 64'(mem_req_size), 64'(e.sz));
            chk("R4 write data", mem_req_wdata, e.d);
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = 10'(a); reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk); reg_we = 1'b0; reg_addr = 10'(a); #1 d = reg_rdata;
   endtask

   task automatic prog(input int ch, input logic [63:0] s, input logic [63:0] dd, input logic [31:0] n);
      wr(B + ch*8 + 1, n);
      wr(B + ch*8 + 2, s[63:32]); wr(B + ch*8 + 3, s[31:0]);
      wr(B + ch*8 + 4, dd[63:32]); wr(B + ch*8 + 5, dd[31:0]);
   endtask

   function automatic logic [31:0] ctlw(input logic [1:0] w, input logic si, input logic di);
      return {1'b1, 4'b0, w, di, si, 23'b0};
   endfunction

   // driver: push the expected write stream for one transfer
   task automatic expect_xfer(input logic [63:0] s, input logic [63:0] dd, input logic [1:0] w,
                              input logic si, input logic di, input int n);
      logic [63:0] m;
      m = (w == 2'd3) ? {64{1'b1}} : ((64'(1) << (8 << w)) - 64'(1));
      for (int e = 0; e < n; e++) begin
         q.push_back('{a: dd, sz: w, d: memword(s) & m});
         if (si) s = s + (64'(1) << w);
         if (di) dd = dd + (64'(1) << w);
      end
   endtask

   task automatic wait_done();
      int guard = 0;
      repeat (3) @(negedge clk);
      while (busy && guard < 2000) begin @(negedge clk); guard++; end
      chk("R10 busy returns low", 64'(busy), 64'd0);
      chk("R6 scoreboard drained", 64'(q.size()), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int ws;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      rd(B + 0, v);  chk("R12 ctrl reset", 64'(v), 64'd0);
      rd(B + 3, v);  chk("R12 source reset", 64'(v), 64'd0);
      rd(B + 32, v); chk("R12 status reset", 64'(v), 64'd0);
      chk("R12 busy reset", 64'(busy), 64'd0);
      chk("R12 no request", 64'(mem_req_valid), 64'd0);

      // R1, R2 register layout and half-word writes
      wr(B + 8 + 2, 32'hDEADBEEF); wr(B + 8 + 3, 32'h12345678);
      wr(B + 8 + 2, 32'hCAFEF00D);
      rd(B + 8 + 2, v); chk("R2 high half replaced", 64'(v), 64'hCAFEF00D);
      rd(B + 8 + 3, v); chk("R2 low half kept", 64'(v), 64'h12345678);
      wr(B + 8 + 6, 32'h0000_00AA); wr(B + 8 + 7, 32'h5555_0000);
      rd(B + 8 + 6, v); chk("R1 chain high slot", 64'(v), 64'hAA);
      rd(B + 8 + 7, v); chk("R1 chain low slot", 64'(v), 64'h5555_0000);

      // R11 unimplemented offsets
      wr(B + 33, 32'hFFFF_FFFF); rd(B + 33, v); chk("R11 above status", 64'(v), 64'd0);
      wr(B - 1, 32'hFFFF_FFFF);  rd(B - 1, v);  chk("R11 below base", 64'(v), 64'd0);
      rd(B + 32, v); chk("R11 status untouched", 64'(v), 64'd0);

      // R4 R5 R7 R10: width 4, both ends step
      prog(0, 64'h000, 64'h400, 32'd4);
      expect_xfer(64'h000, 64'h400, 2'd2, 1'b1, 1'b1, 4);
      wr(B + 0, ctlw(2'd2, 1'b1, 1'b1));
      @(negedge clk); chk("R10 busy after start", 64'(busy), 64'd1);
      wait_done();
      rd(B + 32, v); chk("R7 status bit ch0", 64'(v), 64'h8000_0000);
      rd(B + 0, v);  chk("R7 enable cleared", 64'(v), 64'(ctlw(2'd2, 1'b1, 1'b1) & 32'h7FFF_FFFF));

      // R8 write-one-to-clear
      wr(B + 32, 32'h0000_0000); rd(B + 32, v); chk("R8 zero write keeps", 64'(v), 64'h8000_0000);
      wr(B + 32, 32'h8000_0000); rd(B + 32, v); chk("R8 one clears", 64'(v), 64'd0);

      // R5 width 1, source steps, destination fixed
      prog(1, 64'h040, 64'h500, 32'd3);
      expect_xfer(64'h040, 64'h500, 2'd0, 1'b1, 1'b0, 3);
      wr(B + 8, ctlw(2'd0, 1'b1, 1'b0));
      wait_done();

      // R5 width 8, source fixed, destination steps above 4 GiB
      prog(2, 64'h080, 64'h1_0000_0600, 32'd2);
      expect_xfer(64'h080, 64'h1_0000_0600, 2'd3, 1'b0, 1'b1, 2);
      wr(B + 16, ctlw(2'd3, 1'b0, 1'b1));
      wait_done();
      wr(B + 32, 32'hFFFF_FFFF);

      // R3 zero count: no traffic, no status
      ws = writes_seen;
      prog(3, 64'h0C0, 64'h700, 32'h0001_0000);
      wr(B + 24, ctlw(2'd1, 1'b1, 1'b1));
      wait_done();
      chk("R3 zero count no writes", 64'(writes_seen), 64'(ws));
      rd(B + 32, v); chk("R3 zero count no status", 64'(v), 64'd0);

      // R3 upper count bits ignored
      prog(3, 64'h0C0, 64'h700, 32'h0001_0002);
      expect_xfer(64'h0C0, 64'h700, 2'd1, 1'b1, 1'b1, 2);
      wr(B + 24, ctlw(2'd1, 1'b1, 1'b1));
      wait_done();
      rd(B + 32, v); chk("R3 count low half used", 64'(v), 64'h1000_0000);
      wr(B + 32, 32'hFFFF_FFFF);

      // R9 priority: ch0 running, ch2 then ch1 armed; ch1 must run before ch2
      prog(0, 64'h100, 64'h800, 32'd4);
      prog(1, 64'h140, 64'h900, 32'd3);
      prog(2, 64'h180, 64'hA00, 32'd2);
      expect_xfer(64'h100, 64'h800, 2'd2, 1'b1, 1'b1, 4);
      expect_xfer(64'h140, 64'h900, 2'd1, 1'b1, 1'b1, 3);
      expect_xfer(64'h180, 64'hA00, 2'd0, 1'b1, 1'b1, 2);
      wr(B + 0,  ctlw(2'd2, 1'b1, 1'b1));
      wr(B + 16, ctlw(2'd0, 1'b1, 1'b1));
      wr(B + 8,  ctlw(2'd1, 1'b1, 1'b1));
      wait_done();
      rd(B + 32, v); chk("R9 three completions", 64'(v), 64'hE000_0000);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule